// File: doc/BRIEF.md
# Video Memory Address Generator

This block produces the memory address used to fetch characters for a display controller that builds the picture from rows of characters, each row several scanlines tall. It keeps a running address that advances once per displayed character clock. It also keeps a second copy, the line-start latch, which holds the address where the current character row began. Every scanline of a row reloads the running address from that latch, so each scanline of the row reads the same stretch of memory. The latch moves forward only on the last scanline of a row. The next row therefore begins where the previous one ended.

The start address is written into a holding register at any time. It is read only at frame start, when both the running address and the latch are loaded from it, so a write made during a frame takes effect at the next frame. A variant parameter selects an alternative behaviour. With `VARIANT` = 1, every scanline start inside the first character row (vertical row count 0) reloads from the holding register instead of from the latch. This lets software change the start address from one scanline to the next within that row. Apart from this address latch, the block keeps no buffered copy of any other counter.

Top module: `vid_addr_gen`

## Requirements
- R1: While `rst_n` is low, the running address, the line-start latch and the start-address holding register are all cleared to 0, so `addr` reads 0.
- R2: A cycle with `start_wr` high stores `start_din` in the holding register and does not change `addr`. A load in the same cycle uses the previous holding value.
- R3: A cycle with `frame_start` high loads the holding value into both the running address and the latch. This takes priority over every other action.
- R4: A cycle with `line_start` high and `frame_start` low reloads the running address from the latch. This applies when `VARIANT` is 0, or when `VARIANT` is 1 and `vrow_cnt` is not 0.
- R5: With `VARIANT` = 1, a `line_start` cycle without `frame_start` while `vrow_cnt` is 0 reloads the running address from the holding register.
- R6: On a cycle without `frame_start` where `raster_cnt` equals `max_scan` minus 1 (modulo 2^RW), the latch takes the current running address. On any other cycle without `frame_start`, the latch keeps its value.
- R7: On a cycle with `disp_en` high and neither strobe high, the running address increments by 1 and wraps from 2^AW-1 to 0.
- R8: On a cycle with no strobe and `disp_en` low, the running address keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Write strobe for the start-address holding register |
| start_din | input | AW | Start address value to write |
| disp_en | input | 1 | Displayed character clock: advance the address |
| raster_cnt | input | RW | Scanline index within the current character row |
| max_scan | input | RW | Scanlines-per-row setting |
| vrow_cnt | input | VW | Vertical character row counter |
| frame_start | input | 1 | First scanline start of a frame |
| line_start | input | 1 | Scanline start |
| addr | output | AW | Current video memory address |

## Verification
Every change to `addr` is registered, so the result of an input applied before a rising edge is due right after that edge. The bench drives inputs on the falling edge and compares `addr` on the next falling edge with a model advanced one step by bench functions. The latch and the holding register have no port of their own. Their contents become visible through `addr` only at the first later line start or frame start. The model carries both values forward so that such delayed effects are checked in the cycle they appear. Both variants run in parallel on the same stimulus.

// File: rtl/vid_addr_gen.sv
module vid_addr_gen #(
  parameter int AW      = 14,
  parameter int RW      = 5,
  parameter int VW      = 7,
  parameter int VARIANT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_wr,
  input  logic [AW-1:0] start_din,
  input  logic          disp_en,
  input  logic [RW-1:0] raster_cnt,
  input  logic [RW-1:0] max_scan,
  input  logic [VW-1:0] vrow_cnt,
  input  logic          frame_start,
  input  logic          line_start,
  output logic [AW-1:0] addr
);
  localparam bit ROW0_DIRECT = (VARIANT == 1);

  logic [AW-1:0] hold_q, line_q, addr_q;

  wire last_raster = (raster_cnt == RW'(max_scan - RW'(1)));
  wire from_hold   = ROW0_DIRECT && (vrow_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        hold_q <= '0;
    else if (start_wr) hold_q <= start_din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           addr_q <= '0;
    else if (frame_start) addr_q <= hold_q;
    else if (line_start)  addr_q <= from_hold ? hold_q : line_q;
    else if (disp_en)     addr_q <= addr_q + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           line_q <= '0;
    else if (frame_start) line_q <= hold_q;
    else if (last_raster) line_q <= addr_q;
  end

  assign addr = addr_q;
endmodule

// File: rtl/vid_addr_gen_chk.sv
module vid_addr_gen_chk #(
  parameter int AW      = 14,
  parameter int RW      = 5,
  parameter int VW      = 7,
  parameter int VARIANT = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          disp_en,
  input logic [RW-1:0] raster_cnt,
  input logic [RW-1:0] max_scan,
  input logic [VW-1:0] vrow_cnt,
  input logic          frame_start,
  input logic          line_start,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] hold_q,
  input logic [AW-1:0] line_q
);
  wire v1_row0 = (VARIANT == 1) && (vrow_cnt == '0);
  wire on_last = (raster_cnt == RW'(max_scan - RW'(1)));

  a_r3_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (addr == $past(hold_q)) && (line_q == $past(hold_q)));

  a_r4_line_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && !v1_row0) |=> addr == $past(line_q));

  a_r5_row0_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && v1_row0) |=> addr == $past(hold_q));

  a_r6_latch_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !on_last) |=> $stable(line_q));

  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && !frame_start && !line_start) |=> addr == AW'($past(addr) + AW'(1)));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_en && !frame_start && !line_start) |=> $stable(addr));
endmodule

bind vid_addr_gen vid_addr_gen_chk #(.AW(AW), .RW(RW), .VW(VW), .VARIANT(VARIANT)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .raster_cnt(raster_cnt),
  .max_scan(max_scan), .vrow_cnt(vrow_cnt), .frame_start(frame_start),
  .line_start(line_start), .addr(addr), .hold_q(hold_q), .line_q(line_q)
);

// File: tb/tb_vid_addr_gen.sv
module tb_vid_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 14, RW = 5, VW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_wr = 0, disp_en = 0, frame_start = 0, line_start = 0;
  logic [AW-1:0] start_din = '0;
  logic [RW-1:0] raster_cnt = '0, max_scan = RW'(1);
  logic [VW-1:0] vrow_cnt = '0;
  logic [AW-1:0] addr0, addr1;

  int total = 0, bad = 0, cycles = 0;
  logic [AW-1:0] m_hold, m_addr [2], m_line [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_addr_gen #(.AW(AW), .RW(RW), .VW(VW), .VARIANT(0)) dut (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_din(start_din),
    .disp_en(disp_en), .raster_cnt(raster_cnt), .max_scan(max_scan),
    .vrow_cnt(vrow_cnt), .frame_start(frame_start), .line_start(line_start),
    .addr(addr0));

  vid_addr_gen #(.AW(AW), .RW(RW), .VW(VW), .VARIANT(1)) dut_v1 (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_din(start_din),
    .disp_en(disp_en), .raster_cnt(raster_cnt), .max_scan(max_scan),
    .vrow_cnt(vrow_cnt), .frame_start(frame_start), .line_start(line_start),
    .addr(addr1));

  function automatic logic [AW-1:0] f_addr(input int v, input logic [AW-1:0] a,
      input logic [AW-1:0] ln, input logic [AW-1:0] h);
    if (frame_start) return h;
    if (line_start)  return (v == 1 && vrow_cnt == 0) ? h : ln;
    if (disp_en)     return a + 1'b1;
    return a;
  endfunction

  function automatic logic [AW-1:0] f_line(input logic [AW-1:0] a,
      input logic [AW-1:0] ln, input logic [AW-1:0] h);
    logic [RW-1:0] lastr;
    lastr = max_scan - 1'b1;
    if (frame_start) return h;
    if (raster_cnt == lastr) return a;
    return ln;
  endfunction

  task automatic check(input string req, input int v, input logic [AW-1:0] got,
      input logic [AW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s variant=%0d addr got=%h exp=%h at cycle %0d", req, v, got, exp, cycles);
    end
  endtask

  task automatic step(input string req, input bit wr, input logic [AW-1:0] din,
      input bit fs, input bit ls, input bit de, input int rc, input int ms, input int vr);
    logic [AW-1:0] na [2], nl [2];
    start_wr = wr; start_din = din; frame_start = fs; line_start = ls; disp_en = de;
    raster_cnt = RW'(rc); max_scan = RW'(ms); vrow_cnt = VW'(vr);
    for (int v = 0; v < 2; v++) begin
      na[v] = f_addr(v, m_addr[v], m_line[v], m_hold);
      nl[v] = f_line(m_addr[v], m_line[v], m_hold);
    end
    @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      m_addr[v] = na[v];
      m_line[v] = nl[v];
    end
    if (wr) m_hold = din;
    check(req, 0, addr0, m_addr[0]);
    check(req, 1, addr1, m_addr[1]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_hold = '0;
    for (int v = 0; v < 2; v++) begin m_addr[v] = '0; m_line[v] = '0; end
    start_wr = 1; start_din = 14'h2AAA; disp_en = 1;
    repeat (3) @(negedge clk);
    check("R1 reset", 0, addr0, '0);
    check("R1 reset", 1, addr1, '0);
    rst_n = 1'b1;
    step("R1 hold cleared", 0, '0, 1, 1, 0, 0, 4, 0);
    // R2: write lands in holding register only
    step("R2 write", 1, 14'h1234, 0, 0, 0, 1, 4, 2);
    step("R2 write", 0, '0, 0, 0, 0, 1, 4, 2);
    step("R2 same-cycle load uses old", 1, 14'h0100, 1, 1, 0, 0, 4, 0);
    step("R3 frame load", 0, '0, 1, 1, 0, 0, 4, 0);
    // R7 advance and R8 idle
    for (int i = 0; i < 5; i++) step("R7 advance", 0, '0, 0, 0, 1, 0, 4, 1);
    step("R8 idle", 0, '0, 0, 0, 0, 0, 4, 1);
    step("R4 line reload", 0, '0, 0, 1, 0, 1, 4, 1);
    // R6 capture on last raster, then next row starts there
    for (int i = 0; i < 4; i++) step("R6 last line", 0, '0, 0, 0, 1, 3, 4, 1);
    step("R6 last line blank", 0, '0, 0, 0, 0, 3, 4, 1);
    step("R6 next row start", 0, '0, 0, 1, 0, 0, 4, 2);
    // R5 variant difference in row 0
    step("R5 write", 1, 14'h0777, 0, 0, 0, 1, 4, 0);
    step("R5 row0 line start", 0, '0, 0, 1, 0, 1, 4, 0);
    step("R5 row0 write again", 1, 14'h0888, 0, 0, 1, 2, 4, 0);
    step("R5 row0 line start", 0, '0, 0, 1, 0, 2, 4, 0);
    // R7 wrap
    step("R7 wrap set", 1, 14'h3FFE, 0, 0, 0, 0, 4, 0);
    step("R7 wrap load", 0, '0, 1, 1, 0, 0, 4, 0);
    for (int i = 0; i < 4; i++) step("R7 wrap", 0, '0, 0, 0, 1, 0, 4, 0);
    // max_scan of 0: last raster is 2^RW-1
    step("R6 zero rows", 0, '0, 0, 0, 1, 31, 0, 3);
    step("R6 zero rows", 0, '0, 0, 1, 0, 0, 0, 3);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      step("R3 R4 R5 R6 R7 R8 random",
           ($urandom % 5) == 0, AW'($urandom), ($urandom % 40) == 0,
           ($urandom % 7) == 0, ($urandom % 5) < 3,
           int'($urandom % 4), int'($urandom % 4) + 1, int'($urandom % 3));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule